// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Registers

This block holds the software-visible setup of a DRAM controller in a small array of 32-bit words inside a 4 KB window. A bus master issues one word-sized request per cycle over a valid/write/address/data interface. Reads return one cycle later. Writes update the array one cycle later.

Word 0 is a protection key. Every other word can be changed only while the key word holds the unlock pattern 0xFC600309. The key word can always be written, so storing any other value relocks the block.

Word 1, at byte offset 0x04, is the configuration word. Its value goes out on a dedicated port to the DRAM engine. The read-only bits of this word and its reset value depend on a silicon-variant parameter. The reset value also depends on an input that gives the fitted RAM size in megabytes.

Top module: `memcfg_regs`

## Requirements
- R1: With variant A, reset leaves the configuration word at 0x40 plus a size code in bits 1:0. The size codes are 64 MB=0, 128 MB=1, 256 MB=2 and 512 MB=3. Every other word resets to zero.
- R2: A RAM size that is not in the variant's table gives size code 0.
- R3: A write to byte address 0x000 always stores the full data in the key word, and a read of that address returns it. The block is unlocked only while this word equals 0xFC600309.
- R4: While the block is locked, a write to any in-range word other than the key changes no state. The write raises wr_err_o in the following cycle.
- R5: An accepted write to the configuration word updates only its writable bits, and the read-only bits keep their value. With variant A the read-only mask is 0xFFFFF84C.
- R6: Words 2 to NUM_REGS-1 are plain read/write storage when unlocked.
- R7: A read at a word index of NUM_REGS or more returns zero. A write there is ignored and raises wr_err_o in the following cycle.
- R8: Read data and rd_valid_o appear in the cycle after the read request. rd_valid_o is low in any cycle that does not follow a read.
- R9: An address with bits 1:0 not zero is treated as out of range: a read returns zero, and a write is ignored and flagged.
- R10: An accepted write or any read leaves wr_err_o low in the following cycle.
- R11: With variant B, reset sets the configuration word to 0x1000000C plus a size code. The size codes are 128 MB=0, 256 MB=1, 512 MB=2 and 1024 MB=3. The read-only mask is 0xF00FC04C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address in the window |
| req_wdata_i | input | 32 | Write data |
| ram_size_mb_i | input | SIZE_W | Fitted RAM size in MB, used at reset |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 32 | Read response data |
| wr_err_o | output | 1 | One-cycle flag for a rejected write |
| cfg_o | output | 32 | Current configuration word |

## Verification
The bench drives two instances, one per variant, with the same traffic and checks both. It resets the block across every table size and several unlisted sizes. A wrong size decoder would show a bad code in bits 1:0. The bench also writes all-ones and all-zeros to the configuration word. A merge that lets read-only bits through, or that clears them, would then change the top nibble or bits 6 and 3:2.

The bench relocks the block with near-miss keys, then retries the configuration write. A design that compares only part of the key would accept the write. Misaligned and out-of-window addresses are checked for a zero read and a flagged write. A decoder that drops the low address bits or wraps the index would alias onto live words.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  localparam int DATA_W = 32;
  localparam int KEY_IDX = 0;
  localparam int CFG_IDX = 1;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hFC60_0309;

  typedef enum logic {VAR_A = 1'b0, VAR_B = 1'b1} variant_e;

  // bits software cannot change in the configuration word
  function automatic logic [DATA_W-1:0] ro_mask(variant_e v);
    logic [DATA_W-1:0] m;
    m = 32'h0000_004C;
    if (v == VAR_A) m |= 32'hFFFF_F800;
    else            m |= 32'hF000_0000 | 32'h0008_0000 | 32'h0007_C000;
    return m;
  endfunction

  // reset image of the configuration word without the size code
  function automatic logic [DATA_W-1:0] cfg_base(variant_e v);
    return (v == VAR_A) ? 32'h0000_0040 : 32'h1000_000C;
  endfunction
endpackage

// File: rtl/memcfg_size_enc.sv
module memcfg_size_enc
  import memcfg_pkg::*;
#(
  parameter variant_e VARIANT = VAR_A,
  parameter int       SIZE_W  = 11
) (
  input  logic [SIZE_W-1:0] size_mb_i,
  output logic [1:0]        code_o
);
  // smallest listed size of the variant, doubled per code step
  localparam int BASE_MB = (VARIANT == VAR_A) ? 64 : 128;

  always_comb begin
    code_o = 2'd0;
    for (int k = 0; k < 4; k++) begin
      if (size_mb_i == SIZE_W'(BASE_MB << k)) code_o = 2'(k);
    end
  end
endmodule

// File: rtl/memcfg_decode.sv
module memcfg_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int WORD_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o
);
  logic [WORD_W-1:0] word;

  assign word  = addr_i[ADDR_W-1:2];
  assign idx_o = word[IDX_W-1:0];
  assign hit_o = (addr_i[1:0] == 2'b00) && (word < WORD_W'(NUM_REGS));
endmodule

// File: rtl/memcfg_regfile.sv
module memcfg_regfile
  import memcfg_pkg::*;
#(
  parameter variant_e VARIANT  = VAR_A,
  parameter int       NUM_REGS = 8,
  localparam int      IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic [1:0]                       size_code_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  localparam logic [DATA_W-1:0] RO_MASK  = ro_mask(VARIANT);
  localparam logic [DATA_W-1:0] RST_BASE = cfg_base(VARIANT);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    if (g == CFG_IDX) begin : g_cfg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  regs_o[g] <= RST_BASE | {{(DATA_W-2){1'b0}}, size_code_i};
        else if (sel) regs_o[g] <= (regs_o[g] & RO_MASK) | (wr_data_i & ~RO_MASK);
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  regs_o[g] <= '0;
        else if (sel) regs_o[g] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/memcfg_regs.sv
module memcfg_regs
  import memcfg_pkg::*;
#(
  parameter variant_e VARIANT  = VAR_A,
  parameter int       ADDR_W   = 12,
  parameter int       NUM_REGS = 8,
  parameter int       SIZE_W   = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [SIZE_W-1:0] ram_size_mb_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  output logic              wr_err_o,
  output logic [31:0]       cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] RO_MASK = ro_mask(VARIANT);

  logic [IDX_W-1:0]                idx;
  logic                            hit;
  logic [1:0]                      size_code;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            unlocked, wr_req, rd_req, wr_ok;

  memcfg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) i_decode (
    .addr_i (req_addr_i),
    .idx_o  (idx),
    .hit_o  (hit)
  );

  memcfg_size_enc #(.VARIANT(VARIANT), .SIZE_W(SIZE_W)) i_size_enc (
    .size_mb_i (ram_size_mb_i),
    .code_o    (size_code)
  );

  assign unlocked = (regs[KEY_IDX] == UNLOCK_KEY);
  assign wr_req   = req_valid_i && req_write_i;
  assign rd_req   = req_valid_i && !req_write_i;
  assign wr_ok    = wr_req && hit && ((idx == IDX_W'(KEY_IDX)) || unlocked);

  memcfg_regfile #(.VARIANT(VARIANT), .NUM_REGS(NUM_REGS)) i_regfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_ok),
    .wr_idx_i    (idx),
    .wr_data_i   (req_wdata_i),
    .size_code_i (size_code),
    .regs_o      (regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      wr_err_o   <= 1'b0;
    end else begin
      rd_valid_o <= rd_req;
      wr_err_o   <= wr_req && !wr_ok;
      if (rd_req) rd_data_o <= hit ? regs[idx] : '0;
    end
  end

  assign cfg_o = regs[CFG_IDX];

  p_key_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && req_addr_i == '0) |=> (regs[KEY_IDX] == $past(req_wdata_i)));

  p_locked_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && hit && idx != IDX_W'(KEY_IDX) && !unlocked) |=> ($stable(regs) && wr_err_o));

  p_ro_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && hit && idx == IDX_W'(CFG_IDX)) |=> ((cfg_o & RO_MASK) == ($past(cfg_o) & RO_MASK)));

  p_oor_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !hit) |=> (rd_data_o == '0));

  p_oor_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && !hit) |=> ($stable(regs) && wr_err_o));

  p_rd_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rd_valid_o);

  p_rd_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rd_valid_o);

  p_no_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req || wr_ok || !req_valid_i) |=> !wr_err_o);
endmodule

// File: tb/test_memcfg_regs.sv
module test_memcfg_regs;
  import memcfg_pkg::*;

  localparam int NREG = 8;
  localparam logic [31:0] KEY  = 32'hFC60_0309;
  localparam logic [31:0] RO_A = 32'hFFFF_F84C;
  localparam logic [31:0] RO_B = 32'hF00F_C04C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [10:0] size_mb = 11'd256;
  logic rdv_a, rdv_b, err_a, err_b;
  logic [31:0] rd_a, rd_b, cfg_a, cfg_b;

  int checks = 0, errors = 0;
  logic [31:0] ma [NREG];
  logic [31:0] mb [NREG];

  always #10 clk = ~clk;

  memcfg_regs #(.VARIANT(VAR_A)) i_memcfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .ram_size_mb_i(size_mb),
    .rd_valid_o(rdv_a), .rd_data_o(rd_a), .wr_err_o(err_a), .cfg_o(cfg_a));

  memcfg_regs #(.VARIANT(VAR_B)) i_memcfg_regs_b (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .ram_size_mb_i(size_mb),
    .rd_valid_o(rdv_b), .rd_data_o(rd_b), .wr_err_o(err_b), .cfg_o(cfg_b));

  function automatic logic [1:0] code_a(int mb_v);
    case (mb_v) 64: return 2'd0; 128: return 2'd1; 256: return 2'd2; 512: return 2'd3; default: return 2'd0; endcase
  endfunction
  function automatic logic [1:0] code_b(int mb_v);
    case (mb_v) 128: return 2'd0; 256: return 2'd1; 512: return 2'd2; 1024: return 2'd3; default: return 2'd0; endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(int mb_v);
    size_mb = 11'(mb_v);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) begin ma[i] = '0; mb[i] = '0; end
    ma[1] = 32'h40 | {30'b0, code_a(mb_v)};
    mb[1] = 32'h1000_000C | {30'b0, code_b(mb_v)};
  endtask

  // called on a falling edge; returns on the next falling edge after checking
  task automatic op(bit w, logic [11:0] a, logic [31:0] d);
    int idx;
    bit hit, ok;
    logic [31:0] ea, eb;
    string tg;
    idx = int'(a >> 2);
    hit = (a[1:0] == 2'b00) && (idx < NREG);
    ok  = w && hit && (idx == 0 || ma[0] == KEY);
    ea = hit ? ma[idx] : 32'h0;
    eb = hit ? mb[idx] : 32'h0;
    vld = 1'b1; wr = w; addr = a; wdata = d;
    if (ok) begin
      if (idx == 1) begin
        ma[1] = (ma[1] & RO_A) | (d & ~RO_A);
        mb[1] = (mb[1] & RO_B) | (d & ~RO_B);
      end else begin
        ma[idx] = d; mb[idx] = d;
      end
    end
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
    if (!hit) tg = (a[1:0] != 2'b00) ? "R9" : "R7";
    else if (idx == 0) tg = "R3";
    else if (idx == 1) tg = "R5";
    else tg = "R6";
    if (w) begin
      if (ok) begin
        chk("R10 err a", {31'b0, err_a}, 32'h0);
        chk("R10 err b", {31'b0, err_b}, 32'h0);
      end else begin
        chk(hit ? "R4 err a" : {tg, " err a"}, {31'b0, err_a}, 32'h1);
        chk(hit ? "R4 err b" : {tg, " err b"}, {31'b0, err_b}, 32'h1);
      end
      chk("R8 idle", {31'b0, rdv_a}, 32'h0);
    end else begin
      chk("R8 valid", {31'b0, rdv_a & rdv_b}, 32'h1);
      chk({tg, " rd a"}, rd_a, ea);
      chk({tg, " rd b/R11"}, rd_b, eb);
      chk("R10 rd err", {31'b0, err_a | err_b}, 32'h0);
    end
    chk("R5 cfg a", cfg_a, ma[1]);
    chk("R11 cfg b", cfg_b, mb[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sizes [9] = '{64, 128, 256, 512, 1024, 100, 0, 2047, 32};
    void'($urandom(32'd4242));
    // R1 / R2 / R11 reset images across sizes
    foreach (sizes[s]) begin
      do_reset(sizes[s]);
      @(negedge clk);
      chk("R1 cfg reset a", cfg_a, ma[1]);
      chk("R11 cfg reset b", cfg_b, mb[1]);
      chk("R8 rst idle", {30'b0, rdv_a, err_a}, 32'h0);
    end
    chk("R2 unlisted size a", cfg_a, 32'h40);
    do_reset(256);
    @(negedge clk);
    chk("R1 cfg 256 a", cfg_a, 32'h42);
    chk("R11 cfg 256 b", cfg_b, 32'h1000_000D);

    op(0, 12'h000, 0);                 // R3 key reads zero
    op(0, 12'h008, 0);                 // R1 other word zero
    op(1, 12'h004, 32'h0000_0000);     // R4 locked
    op(1, 12'h000, KEY ^ 32'h1);       // near-miss key
    op(1, 12'h004, 32'h0000_0000);     // R4 still locked
    op(1, 12'h000, KEY);
    op(0, 12'h000, 0);
    op(1, 12'h004, 32'hFFFF_FFFF);     // R5 merge
    op(0, 12'h004, 0);
    op(1, 12'h004, 32'h0000_0000);
    op(0, 12'h004, 0);
    op(1, 12'h01C, 32'hA5A5_1234);     // R6
    op(0, 12'h01C, 0);
    op(0, 12'h020, 0);                 // R7
    op(1, 12'hFFC, 32'hDEAD_BEEF);
    op(1, 12'h006, 32'h1111_1111);     // R9
    op(0, 12'h005, 0);
    op(1, 12'h000, 32'h0000_1234);     // relock
    op(1, 12'h008, 32'h7777_7777);
    op(0, 12'h008, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      bit w;
      case ($urandom % 6)
        0: a = 12'h000;
        1: a = 12'h004;
        2: a = 12'(($urandom % NREG) << 2);
        3: a = 12'($urandom);
        4: a = 12'((($urandom % NREG) << 2) | (1 + $urandom % 3));
        default: a = 12'h004;
      endcase
      w = $urandom % 2 == 1;
      d = $urandom;
      if (a == 12'h000 && ($urandom % 3 != 0)) d = KEY;
      op(w, a, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule